// File: doc/BRIEF.md
# Single-Buffer Serial Port With Register Interface

This block is an asynchronous serial port for 8-bit characters framed as one low start bit, eight data bits sent least significant bit first, no parity and one high stop bit. Software reaches it through six 32-bit word registers on a simple read/write bus, and it signals attention through one level-sensitive interrupt line. Each direction keeps exactly one character. On the transmit side a holding register feeds a shift register. On the receive side a single buffer holds the last completed character.

The bit period is set by a divisor register and equals divisor + 1 clock cycles. The receiver keeps sticky flags for framing errors, breaks and overruns, and a summary bit that is the OR of the error flags. It also raises a flag when a received character equals a programmable match character. The clear-to-send input is synchronized, its current level is shown in the status word and any change of that level is latched. The request-to-send output is a plain software-controlled bit. A single write of any value to the status register clears all sticky flags.

The bus has no back-pressure. A write takes effect at the clock edge on which `reg_wr` is sampled. Read data is combinational from `reg_addr`, and the only read side effect, the clearing of receive-ready, occurs at the edge on which `reg_rd` is sampled with the receive-data address.

Top module: `serial_port_core`

## Requirements
- R1: After reset the status word reads 0x060 while the clear-to-send input is low (bit 5 transmitter-empty = 1, bit 6 transmit-ready = 1), the control word reads 0, the divisor reads the `DIV_INIT` parameter, the match character reads 0, `txd` is high, and `irq` and `rts_out` are low.
- R2: Every transmitted bit lasts exactly divisor + 1 clock cycles. The divisor is at word address 4.
- R3: A character written to word address 1 leaves `txd` as a low start bit, then the eight data bits least significant bit first, then a high stop bit. `txd` is high whenever status bit 5 (transmitter empty) is set.
- R4: Status bit 6 (transmit ready) is low while the holding register is occupied. Status bit 5 (transmitter empty) is set only when the holding register and the shift register are both empty, with the stop bit fully sent. A write to address 1 while the holding register is full is ignored.
- R5: When a frame completes, its character can be read at word address 0 and status bit 7 (receive ready) is set. A read of address 0 clears bit 7.
- R6: If a frame completes while bit 7 is still set, the new character replaces the old one and status bit 3 (overrun) and bit 8 (error summary) are set.
- R7: A frame whose stop bit samples low sets status bit 1 (framing error) and bit 8. The character is still delivered.
- R8: A frame that samples low in every bit, stop bit included, sets status bit 2 (break) in addition to bit 1. The receiver does not look for a new start bit until the line has returned high.
- R9: Any write to word address 2 clears status bits 0 to 3, 8, 10 and 12, and leaves bits 5, 6, 7 and 11 as they were.
- R10: Status bit 12 is set when a received character equals the low 8 bits of word address 5.
- R11: Status bit 11 shows the clear-to-send input after a two-flop synchronizer. Any change of that synchronized level sets status bit 10.
- R12: `irq` is high exactly when some status bit among 5, 6, 7, 8, 10 and 12 is set together with the control bit at the same position (word address 3).
- R13: `rts_out` follows control bit 11 from the edge that writes it. Control bit 11 is not an interrupt source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Word address of the register accessed |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_rd | input | 1 | Read strobe, needed only for the read side effect |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| txd | output | 1 | Serial transmit line, idles high |
| rxd | input | 1 | Serial receive line |
| cts_in | input | 1 | Clear-to-send input |
| rts_out | output | 1 | Request-to-send output |
| irq | output | 1 | Level interrupt request |

## Verification
Register writes, the receive-ready clear on a data read, `rts_out` and `irq` take effect one edge after the strobe. The bench drives each access on a falling edge and samples on the following falling edge, with no extra wait. A change on `cts_in` reaches status bit 11 after two edges and bit 10 after three, so the bench waits four cycles before it checks. Frame-length results vary: transmit ready returns one edge after a transmit write, while receive ready and the error flags appear about ten bit periods later. The bench therefore polls the status word in bounded loops, measures the start-bit width by counting falling edges while `txd` is low, and reads the flags only after the line has settled.

// File: rtl/sercore_pkg.sv
package sercore_pkg;

  typedef enum logic [2:0] {
    RA_RXDATA  = 3'd0,
    RA_TXDATA  = 3'd1,
    RA_STATUS  = 3'd2,
    RA_CTRL    = 3'd3,
    RA_DIVISOR = 3'd4,
    RA_MATCH   = 3'd5
  } reg_addr_e;

  // status / control bit positions (enables share the flag positions)
  localparam int SB_PE   = 0;
  localparam int SB_FE   = 1;
  localparam int SB_BRK  = 2;
  localparam int SB_ROE  = 3;
  localparam int SB_TMT  = 5;
  localparam int SB_TRDY = 6;
  localparam int SB_RRDY = 7;
  localparam int SB_ERR  = 8;
  localparam int SB_DCTS = 10;
  localparam int SB_CTS  = 11;
  localparam int SB_RTS  = 11;
  localparam int SB_EOP  = 12;

  localparam logic [31:0] IRQ_SRC_MASK = (32'd1 << SB_TMT) | (32'd1 << SB_TRDY) |
                                         (32'd1 << SB_RRDY) | (32'd1 << SB_ERR) |
                                         (32'd1 << SB_DCTS) | (32'd1 << SB_EOP);
  localparam logic [31:0] CTRL_MASK = IRQ_SRC_MASK | (32'd1 << SB_RTS);

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_HOLD  = 2'd3
  } rx_state_e;

endpackage

// File: rtl/sercore_sync.sv
module sercore_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sercore_tx.sv
module sercore_tx #(
  parameter int CHAR_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              load,
  input  logic [CHAR_W-1:0] load_data,
  output logic              hold_full,
  output logic              busy,
  output logic              txd
);
  localparam int FRAME_BITS = CHAR_W + 2;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic [CHAR_W-1:0] hold_q;
  logic [CHAR_W:0]   shift_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DIV_W-1:0]  cnt_q;
  logic              start_shift;

  assign start_shift = hold_full && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
      busy      <= 1'b0;
      shift_q   <= '1;
      idx_q     <= '0;
      cnt_q     <= '0;
      txd       <= 1'b1;
    end else begin
      // holding register: a write while full is dropped
      if (load && !hold_full) begin
        hold_full <= 1'b1;
        hold_q    <= load_data;
      end else if (start_shift) begin
        hold_full <= 1'b0;
      end

      if (start_shift) begin
        busy    <= 1'b1;
        shift_q <= {1'b1, hold_q};
        idx_q   <= '0;
        cnt_q   <= div;
        txd     <= 1'b0;
      end else if (busy) begin
        if (cnt_q == '0) begin
          if (idx_q == LAST_IDX) begin
            busy <= 1'b0;
          end else begin
            txd     <= shift_q[0];
            shift_q <= {1'b1, shift_q[CHAR_W:1]};
            idx_q   <= idx_q + 1'b1;
            cnt_q   <= div;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sercore_rx.sv
module sercore_rx
  import sercore_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              rx_s,
  output logic              done,
  output logic [CHAR_W-1:0] data,
  output logic              frame_err,
  output logic              brk
);
  localparam int IDX_W = $clog2(CHAR_W + 1);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(CHAR_W);

  rx_state_e         state_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CHAR_W-1:0] shift_q;
  logic              all_zero_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= RX_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      shift_q    <= '0;
      all_zero_q <= 1'b1;
      done       <= 1'b0;
      data       <= '0;
      frame_err  <= 1'b0;
      brk        <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          if (!rx_s) begin
            state_q <= RX_START;
            cnt_q   <= div >> 1;
          end
        end
        RX_START: begin
          if (cnt_q == '0) begin
            if (rx_s) begin
              state_q <= RX_IDLE;          // glitch, not a start bit
            end else begin
              state_q    <= RX_BITS;
              cnt_q      <= div;
              idx_q      <= '0;
              all_zero_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        RX_BITS: begin
          if (cnt_q == '0) begin
            cnt_q <= div;
            if (idx_q != STOP_IDX) begin
              shift_q <= {rx_s, shift_q[CHAR_W-1:1]};
              if (rx_s) all_zero_q <= 1'b0;
              idx_q <= idx_q + 1'b1;
            end else begin
              done      <= 1'b1;
              data      <= shift_q;
              frame_err <= !rx_s;
              brk       <= all_zero_q && !rx_s;
              state_q   <= rx_s ? RX_IDLE : RX_HOLD;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        RX_HOLD: begin
          if (rx_s) state_q <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_port_core.sv
module serial_port_core
  import sercore_pkg::*;
#(
  parameter int CHAR_W      = 8,
  parameter int DIV_W       = 16,
  parameter int DIV_INIT    = 433,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        txd,
  input  logic        rxd,
  input  logic        cts_in,
  output logic        rts_out,
  output logic        irq
);
  localparam int WORD_W = 32;

  logic [DIV_W-1:0]  div_q;
  logic [CHAR_W-1:0] match_q;
  logic [WORD_W-1:0] ctrl_q;
  logic [CHAR_W-1:0] rx_buf_q;
  logic fe_q, brk_q, roe_q, rrdy_q, dcts_q, eop_q, cts_prev_q;
  logic [WORD_W-1:0] status_w;

  logic wr_tx, wr_stat, wr_ctrl, wr_div, wr_match, rd_rx;
  assign wr_tx    = reg_wr && (reg_addr == RA_TXDATA);
  assign wr_stat  = reg_wr && (reg_addr == RA_STATUS);
  assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
  assign wr_div   = reg_wr && (reg_addr == RA_DIVISOR);
  assign wr_match = reg_wr && (reg_addr == RA_MATCH);
  assign rd_rx    = reg_rd && (reg_addr == RA_RXDATA);

  // line synchronizers
  logic rx_s, cts_s;
  sercore_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s));
  sercore_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cts_sync (
    .clk(clk), .rst_n(rst_n), .d(cts_in), .q(cts_s));

  // transmitter
  logic tx_hold_full, tx_busy;
  sercore_tx #(.CHAR_W(CHAR_W), .DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .div(div_q), .load(wr_tx),
    .load_data(reg_wdata[CHAR_W-1:0]), .hold_full(tx_hold_full),
    .busy(tx_busy), .txd(txd));

  // receiver
  logic              rx_done, rx_ferr, rx_brk;
  logic [CHAR_W-1:0] rx_data;
  sercore_rx #(.CHAR_W(CHAR_W), .DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .div(div_q), .rx_s(rx_s), .done(rx_done),
    .data(rx_data), .frame_err(rx_ferr), .brk(rx_brk));

  // sticky event sources
  logic set_fe, set_brk, set_roe, set_dcts, set_eop;
  assign set_fe   = rx_done && rx_ferr;
  assign set_brk  = rx_done && rx_brk;
  assign set_roe  = rx_done && rrdy_q && !rd_rx;
  assign set_dcts = cts_s != cts_prev_q;
  assign set_eop  = rx_done && (rx_data == match_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q      <= DIV_W'(DIV_INIT);
      match_q    <= '0;
      ctrl_q     <= '0;
      rx_buf_q   <= '0;
      fe_q       <= 1'b0;
      brk_q      <= 1'b0;
      roe_q      <= 1'b0;
      rrdy_q     <= 1'b0;
      dcts_q     <= 1'b0;
      eop_q      <= 1'b0;
      cts_prev_q <= 1'b0;
    end else begin
      if (wr_div)   div_q   <= reg_wdata[DIV_W-1:0];
      if (wr_match) match_q <= reg_wdata[CHAR_W-1:0];
      if (wr_ctrl)  ctrl_q  <= reg_wdata & CTRL_MASK;
      cts_prev_q <= cts_s;

      if (rx_done) begin
        rx_buf_q <= rx_data;
        rrdy_q   <= 1'b1;
      end else if (rd_rx) begin
        rrdy_q   <= 1'b0;
      end

      // a new event wins over a clear in the same cycle
      fe_q   <= set_fe   || (fe_q   && !wr_stat);
      brk_q  <= set_brk  || (brk_q  && !wr_stat);
      roe_q  <= set_roe  || (roe_q  && !wr_stat);
      dcts_q <= set_dcts || (dcts_q && !wr_stat);
      eop_q  <= set_eop  || (eop_q  && !wr_stat);
    end
  end

  always_comb begin
    status_w          = '0;
    status_w[SB_PE]   = 1'b0;
    status_w[SB_FE]   = fe_q;
    status_w[SB_BRK]  = brk_q;
    status_w[SB_ROE]  = roe_q;
    status_w[SB_TMT]  = !tx_busy && !tx_hold_full;
    status_w[SB_TRDY] = !tx_hold_full;
    status_w[SB_RRDY] = rrdy_q;
    status_w[SB_ERR]  = fe_q | brk_q | roe_q;
    status_w[SB_DCTS] = dcts_q;
    status_w[SB_CTS]  = cts_s;
    status_w[SB_EOP]  = eop_q;
  end

  always_comb begin
    unique case (reg_addr)
      RA_RXDATA:  reg_rdata = WORD_W'(rx_buf_q);
      RA_STATUS:  reg_rdata = status_w;
      RA_CTRL:    reg_rdata = ctrl_q;
      RA_DIVISOR: reg_rdata = WORD_W'(div_q);
      RA_MATCH:   reg_rdata = WORD_W'(match_q);
      default:    reg_rdata = '0;
    endcase
  end

  assign irq     = |(status_w & ctrl_q & IRQ_SRC_MASK);
  assign rts_out = ctrl_q[SB_RTS];
endmodule

// File: rtl/sercore_checks.sv
module sercore_checks
  import sercore_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  reg_addr,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic        wdata_rts,
  input logic        txd,
  input logic        rts_out,
  input logic        rx_done,
  input logic [31:0] status_w
);
  logic rd_rx, wr_stat, wr_ctrl;
  assign rd_rx   = reg_rd && (reg_addr == RA_RXDATA);
  assign wr_stat = reg_wr && (reg_addr == RA_STATUS);
  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);

  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status_w[SB_TMT] |-> txd);

  p_empty_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status_w[SB_TMT] |-> status_w[SB_TRDY]);

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !rx_done) |=> !status_w[SB_RRDY]);

  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && status_w[SB_RRDY] && !rd_rx) |=> (status_w[SB_ROE] && status_w[SB_ERR]));

  p_clear_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !rx_done) |=>
      (!status_w[SB_FE] && !status_w[SB_BRK] && !status_w[SB_ROE] && !status_w[SB_EOP]));

  p_cts_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_w[SB_CTS]) |=> status_w[SB_DCTS]);

  p_rts_follow_r13: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (rts_out == $past(wdata_rts)));
endmodule

bind serial_port_core sercore_checks u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .wdata_rts (reg_wdata[11]),
  .txd       (txd),
  .rts_out   (rts_out),
  .rx_done   (rx_done),
  .status_w  (status_w)
);

// File: tb/serial_port_core_test.sv
`timescale 1ns/1ps
module serial_port_core_test;
  localparam int TB_DIV_INIT = 433;
  localparam int WATCHDOG    = 150000;
  localparam logic [2:0] A_RX = 3'd0, A_TX = 3'd1, A_ST = 3'd2, A_CT = 3'd3,
                         A_DV = 3'd4, A_MT = 3'd5;
  // {character, match character, expected match flag}
  localparam logic [16:0] VEC [0:5] = '{
    {8'hA5, 8'h0D, 1'b0}, {8'h0D, 8'h0D, 1'b1}, {8'h00, 8'h0D, 1'b0},
    {8'hFF, 8'hFF, 1'b1}, {8'h3C, 8'hC3, 1'b0}, {8'h81, 8'h81, 1'b1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic txd, rxd, rts_out, irq;
  logic cts_in = 1'b0, rx_drv = 1'b1, loop_en = 1'b1;
  int checks = 0, failures = 0, cur_div = 3;
  logic [31:0] v;

  always #4 clk = ~clk;
  assign rxd = loop_en ? txd : rx_drv;

  serial_port_core #(.DIV_INIT(TB_DIV_INIT)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .txd(txd), .rxd(rxd), .cts_in(cts_in), .rts_out(rts_out), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_rrdy(input string tag);
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); peek(A_ST, s);
      if (s[7]) break;
    end
    chk(tag, {31'd0, s[7]}, 32'd1);
  endtask

  task automatic wait_tmt();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); peek(A_ST, s);
      if (s[5]) break;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stop);
    logic [9:0] bits;
    bits = {stop, d, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rx_drv = bits[i];
      repeat (cur_div + 1) @(negedge clk);
    end
    rx_drv = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic start_width(input int div, input string tag);
    int n;
    wr(A_DV, div); cur_div = div;
    wr(A_TX, 32'hFF);
    for (int i = 0; i < 100 && txd; i++) @(negedge clk);
    n = 0;
    while (txd == 1'b0 && n < 1000) begin n++; @(negedge clk); end
    chk(tag, n, div + 1);
    wait_tmt();
    rd(A_RX, v); wr(A_ST, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    peek(A_ST, v); chk("R1 status", v, 32'h060);
    peek(A_CT, v); chk("R1 control", v, 32'h0);
    peek(A_DV, v); chk("R1 divisor", v, TB_DIV_INIT);
    peek(A_MT, v); chk("R1 match char", v, 32'h0);
    chk("R1 txd idle", {31'd0, txd}, 32'd1);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rts", {31'd0, rts_out}, 32'd0);

    wr(A_DV, 3); cur_div = 3;

    // R3/R5/R10 loopback vector table
    for (int i = 0; i < 6; i++) begin
      wr(A_MT, {24'd0, VEC[i][8:1]});
      wr(A_ST, 0);
      wr(A_TX, {24'd0, VEC[i][16:9]});
      wait_rrdy("R5 receive ready after frame");
      peek(A_ST, v); chk("R10 match flag", {31'd0, v[12]}, {31'd0, VEC[i][0]});
      rd(A_RX, v); chk("R3 loopback char", v, {24'd0, VEC[i][16:9]});
      peek(A_ST, v); chk("R5 read clears receive ready", {31'd0, v[7]}, 32'd0);
      wait_tmt();
    end
    wr(A_ST, 0);

    // R2 bit period
    start_width(3, "R2 start bit cycles div=3");
    start_width(6, "R2 start bit cycles div=6");
    wr(A_DV, 3); cur_div = 3;

    // R4 holding register, then R6 overrun and R9 clear
    wr(A_TX, 32'h12);
    peek(A_ST, v); chk("R4 ready/empty low after write", v & 32'h60, 32'h00);
    repeat (2) @(negedge clk);
    peek(A_ST, v); chk("R4 ready again, not empty", v & 32'h60, 32'h40);
    wr(A_TX, 32'h34);
    wr(A_TX, 32'h99);  // holding full: dropped
    repeat (3) @(negedge clk);
    peek(A_ST, v); chk("R4 ready low while holding full", v & 32'h60, 32'h00);
    wait_tmt();
    repeat (60) @(negedge clk);
    peek(A_ST, v); chk("R4 empty after stop bit", v & 32'h60, 32'h60);
    peek(A_ST, v); chk("R6 overrun and summary", v & 32'h18F, 32'h188);
    wr(A_ST, 0);
    peek(A_ST, v); chk("R9 sticky cleared, receive ready kept", v & 32'h18F, 32'h080);
    rd(A_RX, v); chk("R6 newest char kept, dropped write ignored R4", v, 32'h34);

    // R7 framing error
    loop_en = 1'b0;
    send_frame(8'h55, 1'b0);
    peek(A_ST, v); chk("R7 framing error", v & 32'h187, 32'h182);
    rd(A_RX, v); chk("R7 char delivered", v, 32'h55);
    wr(A_ST, 0);

    // R8 break
    rx_drv = 1'b0;
    repeat (12 * (cur_div + 1)) @(negedge clk);
    rx_drv = 1'b1;
    repeat (10) @(negedge clk);
    peek(A_ST, v); chk("R8 break and framing", v & 32'h187, 32'h186);
    rd(A_RX, v); chk("R8 zero char", v, 32'h0);
    wr(A_ST, 0);
    peek(A_ST, v); chk("R9 all sticky clear", v & 32'h150F, 32'h0);
    loop_en = 1'b1;

    // R11 clear-to-send
    cts_in = 1'b1; repeat (4) @(negedge clk);
    peek(A_ST, v); chk("R11 level and change", v & 32'hC00, 32'hC00);
    wr(A_ST, 0);
    peek(A_ST, v); chk("R9 change cleared, level kept", v & 32'hC00, 32'h800);
    cts_in = 1'b0; repeat (4) @(negedge clk);
    peek(A_ST, v); chk("R11 falling change", v & 32'hC00, 32'h400);

    // R12 interrupt
    wr(A_CT, 32'h400); chk("R12 irq on change enable", {31'd0, irq}, 32'd1);
    wr(A_ST, 0);       chk("R12 irq drops after clear", {31'd0, irq}, 32'd0);
    wr(A_CT, 32'h80);  chk("R12 irq off, ready not enabled", {31'd0, irq}, 32'd0);
    wr(A_TX, 32'h5A);
    wait_rrdy("R12 char for irq");
    chk("R12 irq on receive ready", {31'd0, irq}, 32'd1);
    rd(A_RX, v); chk("R12 irq after read", {31'd0, irq}, 32'd0);
    wait_tmt();
    wr(A_CT, 32'h40);  chk("R12 irq on transmit ready", {31'd0, irq}, 32'd1);
    wr(A_CT, 32'h0);   chk("R12 irq all disabled", {31'd0, irq}, 32'd0);

    // R13 request-to-send
    wr(A_CT, 32'h800);
    chk("R13 rts high", {31'd0, rts_out}, 32'd1);
    chk("R13 rts not an irq source", {31'd0, irq}, 32'd0);
    wr(A_CT, 32'h0);
    chk("R13 rts low", {31'd0, rts_out}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule